// File: doc/BRIEF.md
# Ancillary Packet Checksum Checker and Inserter

This block sits in a 10-bit parallel video word stream. It follows each ancillary data packet from its start marker to its checksum slot and keeps a running 9-bit sum. Every word that carries a strobe comes out exactly one clock later. The only word it can alter is the one at the checksum slot.

A mode input selects how the block treats that slot. When the upstream source already fills in checksums (attached mode), the block compares the received word with its own sum. On a mismatch, a second input picks one of two actions: overwrite the word with the correct value, or pass the word through unchanged and raise a sticky error flag. When the upstream source leaves the slot empty (insert mode), the block always writes its own checksum there. The block does not look at packet types.

Top module: `anc_csum_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `dout` is 000h, `dout_valid` is 0 and `csum_err` is 0.
- R2: Each strobed word appears on `dout` one clock later, with `dout_valid` high for that cycle. Every word outside the checksum slot passes unchanged. When no strobe arrives, `dout` holds its value and `dout_valid` is 0.
- R3: A packet starts when the strobed words 000h, 3FFh, 3FFh arrive in that order while the block is scanning. The next three strobed words are the data ID, the secondary ID or block number, and the data count. Bits 7:0 of the data count give the number of user words. The word after the last user word is the checksum slot. With a count of 0, the slot follows the data count directly.
- R4: The correct checksum word holds, in bits 8:0, the sum of bits 8:0 of the data ID, secondary ID, data count and all user words, modulo 512. Its bit 9 is the inverse of its bit 8.
- R5: With `attach_mode` at 0, the checksum slot is always replaced by the correct checksum word, whatever it held and whatever `force_fix` is. `csum_err` does not change.
- R6: With `attach_mode` at 1 and `force_fix` at 1, a slot word that differs from the correct checksum in any of its 10 bits is replaced by the correct checksum word, and `csum_err` does not change.
- R7: With `attach_mode` at 1 and `force_fix` at 0, a slot word that differs from the correct checksum passes unchanged, and `csum_err` goes to 1 in the following cycle.
- R8: In attached mode, a slot word equal to the correct checksum passes unchanged and never sets `csum_err`.
- R9: `csum_err` stays at 1 until `err_clr` is high at a clock edge. If a new mismatch and `err_clr` fall in the same cycle, the flag stays set.
- R10: After the checksum slot the block goes back to scanning. A 000h, 3FFh, 3FFh run inside a packet's payload does not restart packet framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Strobe marking a valid word on `din` |
| din | input | 10 | Input word |
| attach_mode | input | 1 | 1: packets carry their own checksum; 0: block inserts it |
| force_fix | input | 1 | 1: overwrite a mismatching checksum; 0: report it only |
| err_clr | input | 1 | Clears the sticky error flag |
| dout | output | 10 | Output word, one clock after input |
| dout_valid | output | 1 | Strobe for `dout` |
| csum_err | output | 1 | Sticky checksum mismatch flag |

## Verification
The bench builds the block with the default `DC_BITS` of 8, so the full 8-bit data count is used. This covers an empty payload and a 40-word payload that reaches well past the header. Packets with good and corrupted checksums are sent under all four settings of the two control inputs, with idle gaps between strobes. Further stimulus covers a fake start marker inside a payload and a clear that arrives in the same cycle as a new mismatch.

// File: rtl/anc_csum_unit.sv
module anc_csum_unit #(
  parameter int DC_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       word_valid,
  input  logic [9:0] din,
  input  logic       attach_mode,
  input  logic       force_fix,
  input  logic       err_clr,
  output logic [9:0] dout,
  output logic       dout_valid,
  output logic       csum_err
);
  typedef enum logic [2:0] {SCAN, HDR_ID, HDR_SID, HDR_CNT, PAYLOAD, CSLOT} st_t;

  st_t               st;
  logic [9:0]        h1, h2;
  logic [8:0]        sum;
  logic [DC_BITS-1:0] left;

  wire [8:0] sum_nx  = sum + din[8:0];
  wire [9:0] calc    = {~sum[8], sum};
  wire       at_cs   = word_valid && st == CSLOT;
  wire       bad     = din != calc;
  wire       replace = at_cs && (!attach_mode || (bad && force_fix));
  wire       flag    = at_cs && attach_mode && bad && !force_fix;
  wire       adf     = h2 == 10'h000 && h1 == 10'h3FF && din == 10'h3FF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SCAN;
      h1   <= 10'h3FF;
      h2   <= 10'h3FF;
      sum  <= '0;
      left <= '0;
    end else if (word_valid) begin
      h1 <= din;
      h2 <= h1;
      case (st)
        SCAN:    if (adf) begin st <= HDR_ID; sum <= '0; end
        HDR_ID:  begin sum <= sum_nx; st <= HDR_SID; end
        HDR_SID: begin sum <= sum_nx; st <= HDR_CNT; end
        HDR_CNT: begin
          sum  <= sum_nx;
          left <= din[DC_BITS-1:0];
          st   <= (din[DC_BITS-1:0] == '0) ? CSLOT : PAYLOAD;
        end
        PAYLOAD: begin
          sum  <= sum_nx;
          left <= left - 1'b1;
          if (left == 1) st <= CSLOT;
        end
        default: st <= SCAN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout       <= '0;
      dout_valid <= 1'b0;
      csum_err   <= 1'b0;
    end else begin
      dout_valid <= word_valid;
      if (word_valid) dout <= replace ? calc : din;
      if (flag)         csum_err <= 1'b1;
      else if (err_clr) csum_err <= 1'b0;
    end
  end

  p_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && st != CSLOT |=> dout == $past(din) && dout_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> $stable(dout) && !dout_valid);
  p_csfmt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    at_cs && (!attach_mode || force_fix) |=> dout[9] == ~dout[8]);
  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    at_cs && attach_mode && !force_fix |=> dout == $past(din));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csum_err && !err_clr |=> csum_err);
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !csum_err && !at_cs |=> !csum_err);
  p_insert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    at_cs && !attach_mode |=> $stable(csum_err));
endmodule

// File: tb/test_anc_csum_unit.sv
module test_anc_csum_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       word_valid = 1'b0;
  logic [9:0] din = '0;
  logic       attach_mode = 1'b0;
  logic       force_fix = 1'b0;
  logic       err_clr = 1'b0;
  logic [9:0] dout;
  logic       dout_valid;
  logic       csum_err;

  always #4 clk = ~clk;

  anc_csum_unit #(.DC_BITS(8)) i_anc_csum_unit (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .din(din),
    .attach_mode(attach_mode), .force_fix(force_fix), .err_clr(err_clr),
    .dout(dout), .dout_valid(dout_valid), .csum_err(csum_err)
  );

  int vectors = 0;
  int fails = 0;
  bit m_att = 0, m_frc = 0;
  int e_do = 0, e_dv = 0, e_err = 0;
  string e_tag = "R1";
  int p1 = 1023, p2 = 1023, phase = 0, acc = 0, remain = 0;

  task automatic compare();
    vectors++;
    if (dout_valid !== e_dv[0] || dout !== e_do[9:0] || csum_err !== e_err[0]) begin
      fails++;
      $display("FAIL %s: dout=%h dv=%0d err=%0d expected dout=%h dv=%0d err=%0d",
               e_tag, dout, dout_valid, csum_err, e_do, e_dv, e_err);
    end
  endtask

  task automatic model(input bit v, input int d, input bit clr);
    int o;
    bit seterr;
    int good;
    o = d;
    seterr = 0;
    e_tag = "R2";
    if (v) begin
      case (phase)
        0: if (p2 == 0 && p1 == 1023 && d == 1023) begin phase = 1; acc = 0; end
        1, 2: begin acc = (acc + (d % 512)) % 512; phase++; e_tag = "R3"; end
        3: begin
          acc = (acc + (d % 512)) % 512; remain = d % 256; e_tag = "R3";
          phase = (remain == 0) ? 5 : 4;
        end
        4: begin
          acc = (acc + (d % 512)) % 512; remain--; e_tag = "R3 R10";
          if (remain == 0) phase = 5;
        end
        default: begin
          good = acc + ((acc < 256) ? 512 : 0);
          if (!m_att) begin o = good; e_tag = "R4 R5"; end
          else if (d == good) e_tag = "R8";
          else if (m_frc) begin o = good; e_tag = "R4 R6"; end
          else begin seterr = 1; e_tag = "R7"; end
          phase = 0;
        end
      endcase
      p2 = p1; p1 = d;
      e_do = o;
    end
    e_dv = v;
    if (seterr) e_err = 1;
    else if (clr) begin e_err = 0; e_tag = "R9"; end
  endtask

  task automatic step(input bit v, input int d, input bit clr);
    @(negedge clk);
    compare();
    word_valid = v; din = d[9:0]; err_clr = clr;
    attach_mode = m_att; force_fix = m_frc;
    model(v, d, clr);
  endtask

  function automatic int csum_of(input int w[$]);
    int s = 0;
    foreach (w[i]) s = (s + (w[i] % 512)) % 512;
    return s + ((s < 256) ? 512 : 0);
  endfunction

  task automatic send_pkt(input int did, input int sid, input int n, input int seed,
                          input int corrupt, input bit gaps, input bit fake);
    int body[$];
    int cs;
    body.push_back(did); body.push_back(sid); body.push_back(n);
    for (int i = 0; i < n; i++) body.push_back((seed * 37 + i * 91) % 1024);
    if (fake && n >= 3) begin body[3] = 0; body[4] = 1023; body[5] = 1023; end
    cs = csum_of(body);
    if (!m_att) cs = 0;
    else cs = cs ^ corrupt;
    step(1, 0, 0); step(1, 1023, 0); step(1, 1023, 0);
    foreach (body[i]) begin
      step(1, body[i], 0);
      if (gaps && (i % 3 == 1)) step(0, 0, 0);
    end
    step(1, cs, 0);
    step(0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) begin @(negedge clk); compare(); end
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0); step(0, 0, 0);
    for (int a = 0; a < 2; a++)
      for (int f = 0; f < 2; f++) begin
        m_att = a[0]; m_frc = f[0];
        send_pkt(10'h041, 10'h005, 4, a * 2 + f, 0, 0, 0);
        send_pkt(10'h161, 10'h101, 7, a + 5, 1, 1, 0);
        send_pkt(10'h2F0, 10'h0AA, 5, 9, 10'h200, 0, 0);
        step(0, 0, 1);
        step(0, 0, 0);
      end
    // R3: empty payload; R10: fake marker inside payload
    m_att = 1; m_frc = 0;
    send_pkt(10'h1FF, 10'h1FF, 0, 0, 0, 0, 0);
    send_pkt(10'h0FF, 10'h3FF, 40, 3, 0, 1, 1);
    send_pkt(10'h0FF, 10'h3FF, 10, 4, 3, 0, 1);
    // R9: flag holds across traffic, set wins over a same-cycle clear
    send_pkt(10'h050, 10'h060, 2, 7, 0, 0, 0);
    step(1, 0, 0); step(1, 1023, 0); step(1, 1023, 0);
    step(1, 3, 0); step(1, 4, 0); step(1, 0, 0);
    step(1, 5, 1);
    step(0, 0, 0); step(0, 0, 1); step(0, 0, 0);
    m_att = 0; m_frc = 1;
    send_pkt(10'h3C0, 10'h001, 255, 11, 0, 0, 0);
    repeat (4) step(0, 0, 0);
    @(negedge clk); compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule